// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Comparator

This block creates the carrier comparison for a multilevel converter leg. For an m-level output it uses m−1 triangular carriers. All carriers share one frequency and one amplitude. Each carrier is raised by a fixed offset so that it sits in its own band between two adjacent output levels. The bands touch end to end and together cover the whole reference range. A single up/down counter is the time base for every carrier. A carrier that must run in antiphase uses the mirror of that count.

A two-bit runtime select chooses how the carriers are phased against each other:
- Every carrier in phase with the others.
- The lower half of the carriers in antiphase with the upper half.
- Each carrier in antiphase with the carriers next to it.

The select is sampled only at the valley of the carrier period. A change therefore never cuts a carrier ramp in half.

The block has two registered outputs. The first holds one comparator bit per carrier. The second is the resulting output level, which is the number of carriers the reference exceeds. The switching pattern for each cell is decoded downstream from these outputs.

Top module: `lspwm_gen`

## Requirements
- R1: While `rst` is high, `cmpOut` and `levelOut` are all zeros, the shared count is held at 0, and the phasing scheme is reset to in-phase. The first clock edge after reset is released starts a rising ramp.
- R2: The shared count steps by one on every clock. It runs 0,1,…,BAND_STEPS and then back down to 1, so one carrier period lasts 2·BAND_STEPS cycles. Carrier k (k = 0 for the lowest band) equals k·BAND_STEPS plus either the count or its mirror (BAND_STEPS − count).
- R3: `cmpOut[k]` is 1 exactly when `refLevel` is strictly greater than carrier k. The value is registered and appears one clock after the count, scheme and reference that produced it.
- R4: `levelOut` equals the number of set bits in `cmpOut`, so it ranges from 0 to NUM_LEVELS−1.
- R5: With scheme code 0, every carrier uses the plain count. Code 3 behaves the same as code 0.
- R6: With scheme code 1, carriers k < (NUM_LEVELS−1)/2 (integer division) use the mirrored count and the other carriers use the plain count.
- R7: With scheme code 2, carriers with odd k use the mirrored count and carriers with even k use the plain count.
- R8: `dispSel` is sampled only at the clock edge that ends a cycle in which the count is 0. A value applied at any other time has no effect until the next such edge.
- R9: A `refLevel` of 0 gives `cmpOut` all zeros. A `refLevel` above (NUM_LEVELS−1)·BAND_STEPS gives all ones and `levelOut` = NUM_LEVELS−1, whatever the scheme or the count.
- R10: `cmpOut` is always a thermometer code. If bit k is set, every bit below k is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dispSel | input | 2 | Carrier phasing scheme: 0 in-phase, 1 half-opposed, 2 alternating, 3 same as 0 |
| refLevel | input | REF_W | Unsigned reference; 0 is the bottom of the lowest band |
| cmpOut | output | NUM_LEVELS−1 | Registered comparator bit per carrier, bit 0 for the lowest band |
| levelOut | output | $clog2(NUM_LEVELS) | Registered output level, 0 to NUM_LEVELS−1 |

## Verification
Some properties are checked on every cycle. These are:
- the bounds and unit step of the shared count and its turn at the peak;
- that the scheme holds between valleys;
- the thermometer shape of the comparator word and its agreement with the level;
- saturation at both ends of the reference range.

Other properties can only be shown by the bench's scenarios. These are:
- which carriers are mirrored under each scheme;
- the exact cycle at which a new scheme takes over;
- the duty that a fixed reference produces over one carrier period.

The bench covers them by tracking its own count and scheme from the requirements and comparing every output on every cycle.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;

  // Carrier phasing schemes; code 3 falls back to in-phase.
  typedef enum logic [1:0] {
    DISP_INPHASE = 2'd0,
    DISP_OPPOSE  = 2'd1,
    DISP_ALTERN  = 2'd2,
    DISP_SPARE   = 2'd3
  } dispMode_e;

  // Strobes from control to datapath: which carrier groups use the mirrored count.
  typedef struct packed {
    logic mirrorLower;
    logic mirrorOdd;
  } ctlStrobes_t;

endpackage

// File: rtl/lspwm_ctrl.sv
module lspwm_ctrl
  import lspwm_pkg::*;
#(
  parameter int BAND_STEPS = 8,
  parameter int CNT_W      = $clog2(BAND_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       dispSel,
  output logic [CNT_W-1:0] triCount,
  output ctlStrobes_t      strobes
);

  localparam logic [CNT_W-1:0] PEAK = CNT_W'(BAND_STEPS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             rising;
  dispMode_e        activeMode;
  logic             atValley;

  assign atValley = (cnt == '0);

  // Shared triangle time base plus the scheme register, which loads only at the valley.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      rising     <= 1'b1;
      activeMode <= DISP_INPHASE;
    end else begin
      if (rising) begin
        cnt <= cnt + ONE;
        if (cnt + ONE == PEAK) rising <= 1'b0;
      end else begin
        cnt <= cnt - ONE;
        if (cnt - ONE == '0) rising <= 1'b1;
      end
      if (atValley) activeMode <= dispMode_e'(dispSel);
    end
  end

  always_comb begin
    strobes.mirrorLower = (activeMode == DISP_OPPOSE);
    strobes.mirrorOdd   = (activeMode == DISP_ALTERN);
  end

  assign triCount = cnt;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= PEAK);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cnt == $past(cnt) + ONE) || (cnt + ONE == $past(cnt))));

  // R2
  peak_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == PEAK) |=> (cnt == PEAK - ONE));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(atValley)) |-> $stable(activeMode));

endmodule

// File: rtl/lspwm_dpath.sv
module lspwm_dpath
  import lspwm_pkg::*;
#(
  parameter int NUM_CARR   = 4,
  parameter int BAND_STEPS = 8,
  parameter int CNT_W      = $clog2(BAND_STEPS + 1),
  parameter int REF_W      = 7,
  parameter int LVL_W      = $clog2(NUM_CARR + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    triCount,
  input  ctlStrobes_t         strobes,
  input  logic [REF_W-1:0]    refLevel,
  output logic [NUM_CARR-1:0] cmpOut,
  output logic [LVL_W-1:0]    levelOut
);

  localparam int SPAN = NUM_CARR * BAND_STEPS;

  logic [NUM_CARR-1:0] cmpNext;
  logic [LVL_W-1:0]    levelNext;
  logic [CNT_W-1:0]    mirroredCount;

  assign mirroredCount = CNT_W'(BAND_STEPS) - triCount;

  // One offset carrier and one comparator per band.
  for (genvar k = 0; k < NUM_CARR; k++) begin : g_band
    localparam bit IS_LOWER = (k < NUM_CARR / 2);
    localparam bit IS_ODD   = (k % 2 == 1);
    logic             useMirror;
    logic [CNT_W-1:0] rampVal;
    int               carrierVal;

    assign useMirror  = (strobes.mirrorLower && IS_LOWER) || (strobes.mirrorOdd && IS_ODD);
    assign rampVal    = useMirror ? mirroredCount : triCount;
    assign carrierVal = k * BAND_STEPS + int'(rampVal);
    assign cmpNext[k] = int'(refLevel) > carrierVal;
  end

  always_comb begin
    levelNext = '0;
    for (int i = 0; i < NUM_CARR; i++) begin
      levelNext = levelNext + LVL_W'(cmpNext[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpOut   <= '0;
      levelOut <= '0;
    end else begin
      cmpOut   <= cmpNext;
      levelOut <= levelNext;
    end
  end

  // R10
  therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (cmpOut & (cmpOut + NUM_CARR'(1))) == '0);

  // R4
  level_count_chk: assert property (@(posedge clk) disable iff (rst)
    int'(levelOut) == $countones(cmpOut));

  // R9
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (int'($past(refLevel)) > SPAN)) |-> (int'(levelOut) == NUM_CARR));

  // R9
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(refLevel) == '0)) |-> (cmpOut == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (cmpOut == '0 && levelOut == '0));

endmodule

// File: rtl/lspwm_gen.sv
module lspwm_gen
  import lspwm_pkg::*;
#(
  parameter int  NUM_LEVELS = 5,
  parameter int  BAND_STEPS = 8,
  parameter int  REF_W      = 7,
  localparam int NUM_CARR   = NUM_LEVELS - 1,
  localparam int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          dispSel,
  input  logic [REF_W-1:0]    refLevel,
  output logic [NUM_CARR-1:0] cmpOut,
  output logic [LVL_W-1:0]    levelOut
);

  localparam int CNT_W = $clog2(BAND_STEPS + 1);

  logic [CNT_W-1:0] triCount;
  ctlStrobes_t      strobes;

  lspwm_ctrl #(
    .BAND_STEPS(BAND_STEPS),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .dispSel (dispSel),
    .triCount(triCount),
    .strobes (strobes)
  );

  lspwm_dpath #(
    .NUM_CARR  (NUM_CARR),
    .BAND_STEPS(BAND_STEPS),
    .CNT_W     (CNT_W),
    .REF_W     (REF_W),
    .LVL_W     (LVL_W)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .triCount(triCount),
    .strobes (strobes),
    .refLevel(refLevel),
    .cmpOut  (cmpOut),
    .levelOut(levelOut)
  );

endmodule

// File: tb/lspwm_gen_test.sv
module lspwm_gen_test;

  localparam int NUM_LEVELS = 5;
  localparam int BAND_STEPS = 8;
  localparam int REF_W      = 7;
  localparam int NC         = NUM_LEVELS - 1;
  localparam int LVL_W      = $clog2(NUM_LEVELS);
  localparam int SPAN       = NC * BAND_STEPS;
  localparam int HOLD       = 2 * BAND_STEPS + 3;
  localparam int NSTIM      = 12;

  // {dispSel, refLevel}
  localparam logic [8:0] STIM [NSTIM] = '{
    {2'd0, 7'd0},  {2'd0, 7'd5},   {2'd0, 7'd13}, {2'd1, 7'd13},
    {2'd1, 7'd20}, {2'd2, 7'd20},  {2'd2, 7'd11}, {2'd3, 7'd27},
    {2'd0, 7'd32}, {2'd1, 7'd33},  {2'd2, 7'd127},{2'd1, 7'd16}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       dispSel = 2'd0;
  logic [REF_W-1:0] refLevel = '0;
  logic [NC-1:0]    cmpOut;
  logic [LVL_W-1:0] levelOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lspwm_gen #(.NUM_LEVELS(NUM_LEVELS), .BAND_STEPS(BAND_STEPS), .REF_W(REF_W)) uut (
    .clk(clk), .rst(rst), .dispSel(dispSel), .refLevel(refLevel),
    .cmpOut(cmpOut), .levelOut(levelOut)
  );

  // Reference model built from R1, R2, R3, R5-R8.
  int            mCnt;
  bit            mUp;
  int            mMode;
  logic [NC-1:0] expCmp;
  int            expLvl;

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mUp = 1'b1; mMode = 0; expCmp = '0; expLvl = 0;
    end else begin
      expLvl = 0;
      for (int k = 0; k < NC; k++) begin
        bit mir;
        int ramp;
        mir  = (mMode == 1 && k < NC / 2) || (mMode == 2 && (k % 2) == 1);
        ramp = mir ? BAND_STEPS - mCnt : mCnt;
        expCmp[k] = int'(refLevel) > k * BAND_STEPS + ramp;
        expLvl += int'(expCmp[k]);
      end
      if (mCnt == 0) mMode = int'(dispSel);
      if (mUp) begin
        mCnt++;
        if (mCnt == BAND_STEPS) mUp = 1'b0;
      end else begin
        mCnt--;
        if (mCnt == 0) mUp = 1'b1;
      end
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string modeTag();
    int eff = (int'(dispSel) == 3) ? 0 : int'(dispSel);
    int cur = (mMode == 3) ? 0 : mMode;
    if (refLevel == 0 || int'(refLevel) > SPAN) return "R9";
    if (eff != cur) return "R8";
    if (cur == 1) return "R6";
    if (cur == 2) return "R7";
    return "R5";
  endfunction

  task automatic checkCycle();
    string t = modeTag();
    checkEq({t, "/R3 cmpOut"}, int'(cmpOut), int'(expCmp));
    checkEq("R4 levelOut", int'(levelOut), expLvl);
    checkEq("R10 thermometer", int'((cmpOut & (cmpOut + NC'(1))) == '0), 1);
  endtask

  initial begin
    // R1: outputs held at zero during reset
    repeat (3) @(negedge clk);
    refLevel = 7'd40;
    @(negedge clk);
    checkEq("R1 cmpOut in reset", int'(cmpOut), 0);
    checkEq("R1 levelOut in reset", int'(levelOut), 0);
    rst = 1'b0;

    // Table walk: every output compared with the model on every cycle.
    for (int i = 0; i < NSTIM; i++) begin
      dispSel  = STIM[i][8:7];
      refLevel = STIM[i][6:0];
      for (int c = 0; c < HOLD; c++) begin
        @(negedge clk);
        checkCycle();
      end
    end

    // R2: with in-phase carriers and ref 4, bit 0 is high 7 of 16 cycles per period.
    dispSel  = 2'd0;
    refLevel = 7'd4;
    repeat (2 * BAND_STEPS + 2) @(negedge clk);
    begin
      int highs = 0;
      for (int c = 0; c < 2 * BAND_STEPS; c++) begin
        @(negedge clk);
        highs += int'(cmpOut[0]);
        checkCycle();
      end
      checkEq("R2 duty of lowest carrier", highs, 7);
    end

    // R8: change scheme mid-period and keep checking against the valley-latched model.
    refLevel = 7'd12;
    dispSel  = 2'd2;
    for (int c = 0; c < 3 * BAND_STEPS; c++) begin
      @(negedge clk);
      if (c == 5) dispSel = 2'd1;
      checkCycle();
    end

    // R1: reset in the middle of a run clears outputs and restarts the ramp.
    rst = 1'b1;
    @(negedge clk);
    checkEq("R1 cmpOut after mid-run reset", int'(cmpOut), 0);
    checkEq("R1 levelOut after mid-run reset", int'(levelOut), 0);
    rst = 1'b0;
    refLevel = 7'd9;
    dispSel  = 2'd0;
    for (int c = 0; c < 2 * BAND_STEPS; c++) begin
      @(negedge clk);
      checkCycle();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule